// File: doc/BRIEF.md
# System-Control Coprocessor Register Unit

This block executes the privileged coprocessor instructions of a small 32-bit core that follows the classic RISC load/store model. The core presents an instruction word with a valid strobe, the value read from the source general-purpose register, and the current program counter. The block decodes the word. It moves values between the general-purpose file and its own control registers, performs exception returns, and reports coprocessor numbers that it does not serve. Results come out one clock after the instruction is accepted: a register write-back, a program-counter redirect, or a one-cycle flag.

The block holds a status word, an exception cause word, the exception return address, the faulting data address, a debug control word and a debug return address. A generic 32-entry array backs every other register number. The memory unit can report an unmapped or misaligned data access at any time. The block then records the faulting address and the program counter, enters exception level, and raises the matching exception flag.

Top module: `cp0_ctrl_unit`

## Requirements
- R1: While rst_n is low, and after its release, Status reads 0x00000004 (ERL, bit 2, set) and every other register reads zero. All output strobes and flags are low.
- R2: Only words with bits 31:28 equal to 0100 are acted on. Bits 27:26 select the coprocessor. Numbers 1 and 3 pulse resv_instr_exc. Number 2 pulses cop2_unhandled and changes no register.
- R3: For coprocessor 0, bits 25:21 are the sub-opcode, 20:16 rt, 15:11 rd and 10:0 the tail. Sub-opcodes 0 and 1 read a register and 4 and 5 write one, but only when the tail is zero. A write stores the low 32 bits of rt_value. A read drives wb_en, wb_reg=rt and the value the register held before that edge, one cycle after the instruction.
- R4: rd 8 is BadVAddr, 12 Status, 13 Cause, 14 EPC, 16 Debug and 17 the debug return address. Every other number uses the generic array. A read returns the 32-bit value sign-extended to 64 bits.
- R5: A move sub-opcode with a non-zero tail is not a move. It pulses cop0_unrecog and leaves the target register unchanged.
- R6: Sub-opcode 0x10 with tail bits 5:0 = 0x18 redirects to EPC. If Status bit 2 (ERL) is set it clears only ERL; otherwise it clears Status bit 1 (EXL).
- R7: Sub-opcode 0x10 with tail bits 5:0 = 0x10 sets Status[3:0] to the old Status[5:2] and keeps Status[31:4]. It causes no redirect.
- R8: Sub-opcode 0x10 with tail bits 5:0 = 0x1F clears Debug bit 30 and redirects to the debug return address.
- R9: Any other coprocessor-0 encoding pulses cop0_unrecog for one cycle and changes no register.
- R10: A memory fault report loads BadVAddr with the address, EPC with cur_pc and Status.EXL with 1. It writes Cause[6:2] with 4 for a misaligned read, 5 for a misaligned write, 2 for an unmapped read and 3 for an unmapped write. One cycle later it pulses addr_load_exc, addr_store_exc or data_ref_exc to match. A fault overrides a same-cycle instruction write to these registers.
- R11: With instr_valid low, the instruction word has no effect and no strobe rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr_word | input | 32 | Instruction word |
| rt_value | input | 32 | General-purpose register value for rt |
| cur_pc | input | 32 | Program counter of the current instruction |
| mem_fault_valid | input | 1 | Memory unit reports a faulting access |
| mem_fault_unaligned | input | 1 | 1 = misaligned, 0 = unmapped |
| mem_fault_write | input | 1 | 1 = store, 0 = load |
| mem_fault_addr | input | 32 | Faulting data address |
| wb_en | output | 1 | Write-back to the general-purpose file |
| wb_reg | output | 5 | Write-back register index |
| wb_data | output | 64 | Sign-extended write-back value |
| redir_valid | output | 1 | Program-counter redirect strobe |
| redir_pc | output | 32 | Redirect target |
| resv_instr_exc | output | 1 | Reserved-instruction exception |
| cop2_unhandled | output | 1 | Coprocessor 2 instruction with no handler |
| cop0_unrecog | output | 1 | Unrecognised coprocessor-0 encoding |
| addr_load_exc | output | 1 | Misaligned load exception |
| addr_store_exc | output | 1 | Misaligned store exception |
| data_ref_exc | output | 1 | Unmapped data reference exception |

## Verification
The bench sweeps every register number through write and read with both sub-opcode variants and values that alternate the sign bit. A wrong map would send a dedicated register into the generic array, and a missing sign extension would clear the upper half of wb_data. It runs the exception return with ERL both set and clear. A design that clears the wrong bit would leave EXL set after the second return. It checks that the legacy pop keeps the upper status bits, that a move with a non-zero tail does not write, and that each of the four fault kinds gives its own cause code. It also checks that a fault wins over a same-cycle write to EPC; a design with the priority reversed would keep the instruction's value.

// File: rtl/cp0_pkg.sv
package cp0_pkg;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_MFC,
    OP_MTC,
    OP_ERET,
    OP_RFE,
    OP_DERET,
    OP_UNREC,
    OP_RESV,
    OP_COP2
  } cp0_op_e;

  typedef struct packed {
    cp0_op_e    op;
    logic [4:0] rt;
    logic [4:0] rd;
  } cp0_dec_t;

  localparam logic [3:0] GRP_COP   = 4'b0100;
  localparam logic [4:0] SUB_RET   = 5'h10;
  localparam logic [5:0] FN_ERET   = 6'h18;
  localparam logic [5:0] FN_RFE    = 6'h10;
  localparam logic [5:0] FN_DERET  = 6'h1F;

  localparam logic [4:0] RN_BADV   = 5'd8;
  localparam logic [4:0] RN_STATUS = 5'd12;
  localparam logic [4:0] RN_CAUSE  = 5'd13;
  localparam logic [4:0] RN_EPC    = 5'd14;
  localparam logic [4:0] RN_DEBUG  = 5'd16;
  localparam logic [4:0] RN_DEPC   = 5'd17;

  localparam int ST_EXL = 1;
  localparam int ST_ERL = 2;
  localparam int DBG_DM = 30;

  localparam logic [4:0] EXC_TLBL = 5'd2;
  localparam logic [4:0] EXC_TLBS = 5'd3;
  localparam logic [4:0] EXC_ADEL = 5'd4;
  localparam logic [4:0] EXC_ADES = 5'd5;

  function automatic logic is_dedicated(input logic [4:0] rn);
    return (rn == RN_BADV) || (rn == RN_STATUS) || (rn == RN_CAUSE) ||
           (rn == RN_EPC) || (rn == RN_DEBUG) || (rn == RN_DEPC);
  endfunction

endpackage

// File: rtl/cp0_decoder.sv
module cp0_decoder
  import cp0_pkg::*;
(
  input  logic        valid,
  input  logic [31:0] instr,
  output cp0_dec_t    dec
);

  logic [1:0]  cop;
  logic [4:0]  code;
  logic [10:0] tail;
  logic        is_move;

  always_comb begin
    cop     = instr[27:26];
    code    = instr[25:21];
    tail    = instr[10:0];
    is_move = (code[4:3] == 2'b00) && !code[1] && (tail == '0);
    dec.rt  = instr[20:16];
    dec.rd  = instr[15:11];
    dec.op  = OP_NONE;
    if (valid && instr[31:28] == GRP_COP) begin
      unique case (cop)
        2'd0: begin
          if (is_move)
            dec.op = code[2] ? OP_MTC : OP_MFC;
          else if (code == SUB_RET && tail[5:0] == FN_ERET)
            dec.op = OP_ERET;
          else if (code == SUB_RET && tail[5:0] == FN_RFE)
            dec.op = OP_RFE;
          else if (code == SUB_RET && tail[5:0] == FN_DERET)
            dec.op = OP_DERET;
          else
            dec.op = OP_UNREC;
        end
        2'd2:    dec.op = OP_COP2;
        default: dec.op = OP_RESV;
      endcase
    end
  end

endmodule

// File: rtl/cp0_sys_regs.sv
module cp0_sys_regs
  import cp0_pkg::*;
#(
  parameter int RW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  cp0_op_e       op,
  input  logic [4:0]    rd,
  input  logic [RW-1:0] wdata,
  input  logic [RW-1:0] pc,
  input  logic          flt_valid,
  input  logic          flt_unaligned,
  input  logic          flt_write,
  input  logic [RW-1:0] flt_addr,
  output logic [RW-1:0] status_q,
  output logic [RW-1:0] cause_q,
  output logic [RW-1:0] epc_q,
  output logic [RW-1:0] badv_q,
  output logic [RW-1:0] debug_q,
  output logic [RW-1:0] depc_q
);

  localparam logic [RW-1:0] STATUS_RST = RW'(1) << ST_ERL;

  logic [RW-1:0] status_d, cause_d, epc_d, badv_d, debug_d, depc_d;
  logic          upd_en;
  logic [4:0]    flt_code;

  always_comb begin
    if (flt_unaligned) flt_code = flt_write ? EXC_ADES : EXC_ADEL;
    else               flt_code = flt_write ? EXC_TLBS : EXC_TLBL;
  end

  always_comb begin
    upd_en   = flt_valid || (op == OP_MTC) || (op == OP_ERET) ||
               (op == OP_RFE) || (op == OP_DERET);
    status_d = status_q;
    cause_d  = cause_q;
    epc_d    = epc_q;
    badv_d   = badv_q;
    debug_d  = debug_q;
    depc_d   = depc_q;

    unique case (op)
      OP_MTC: begin
        unique case (rd)
          RN_BADV:   badv_d   = wdata;
          RN_STATUS: status_d = wdata;
          RN_CAUSE:  cause_d  = wdata;
          RN_EPC:    epc_d    = wdata;
          RN_DEBUG:  debug_d  = wdata;
          RN_DEPC:   depc_d   = wdata;
          default: ;
        endcase
      end
      OP_ERET: begin
        if (status_q[ST_ERL]) status_d[ST_ERL] = 1'b0;
        else                  status_d[ST_EXL] = 1'b0;
      end
      OP_RFE:   status_d = {status_q[RW-1:4], status_q[5:2]};
      OP_DERET: debug_d[DBG_DM] = 1'b0;
      default: ;
    endcase

    if (flt_valid) begin
      badv_d           = flt_addr;
      epc_d            = pc;
      status_d[ST_EXL] = 1'b1;
      cause_d[6:2]     = flt_code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= STATUS_RST;
      cause_q  <= '0;
      epc_q    <= '0;
      badv_q   <= '0;
      debug_q  <= '0;
      depc_q   <= '0;
    end else if (upd_en) begin
      status_q <= status_d;
      cause_q  <= cause_d;
      epc_q    <= epc_d;
      badv_q   <= badv_d;
      debug_q  <= debug_d;
      depc_q   <= depc_d;
    end
  end

endmodule

// File: rtl/cp0_gen_array.sv
module cp0_gen_array #(
  parameter int RW   = 32,
  parameter int NREG = 32,
  parameter int IW   = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [RW-1:0] wdata,
  input  logic [IW-1:0] ridx,
  output logic [RW-1:0] rdata
);

  logic [RW-1:0] ent_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    logic ent_en;
    assign ent_en = we && (widx == IW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ent_q[i] <= '0;
      else if (ent_en) ent_q[i] <= wdata;
    end
  end

  assign rdata = ent_q[ridx];

endmodule

// File: rtl/cp0_ctrl_unit.sv
module cp0_ctrl_unit
  import cp0_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int RW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid,
  input  logic [31:0]     instr_word,
  input  logic [RW-1:0]   rt_value,
  input  logic [RW-1:0]   cur_pc,
  input  logic            mem_fault_valid,
  input  logic            mem_fault_unaligned,
  input  logic            mem_fault_write,
  input  logic [RW-1:0]   mem_fault_addr,
  output logic            wb_en,
  output logic [4:0]      wb_reg,
  output logic [XLEN-1:0] wb_data,
  output logic            redir_valid,
  output logic [RW-1:0]   redir_pc,
  output logic            resv_instr_exc,
  output logic            cop2_unhandled,
  output logic            cop0_unrecog,
  output logic            addr_load_exc,
  output logic            addr_store_exc,
  output logic            data_ref_exc
);

  localparam int RNW  = 5;
  localparam int NREG = 1 << RNW;
  localparam int EXTW = XLEN - RW;

  cp0_dec_t      dec;
  logic [RW-1:0] status_q, cause_q, epc_q, badv_q, debug_q, depc_q;
  logic [RW-1:0] gen_rdata, rd_val;
  logic          gen_we;

  cp0_decoder u_dec (
    .valid (instr_valid),
    .instr (instr_word),
    .dec   (dec)
  );

  cp0_sys_regs #(.RW(RW)) u_sys (
    .clk           (clk),
    .rst_n         (rst_n),
    .op            (dec.op),
    .rd            (dec.rd),
    .wdata         (rt_value),
    .pc            (cur_pc),
    .flt_valid     (mem_fault_valid),
    .flt_unaligned (mem_fault_unaligned),
    .flt_write     (mem_fault_write),
    .flt_addr      (mem_fault_addr),
    .status_q      (status_q),
    .cause_q       (cause_q),
    .epc_q         (epc_q),
    .badv_q        (badv_q),
    .debug_q       (debug_q),
    .depc_q        (depc_q)
  );

  assign gen_we = (dec.op == OP_MTC) && !is_dedicated(dec.rd);

  cp0_gen_array #(.RW(RW), .NREG(NREG), .IW(RNW)) u_gen (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (gen_we),
    .widx  (dec.rd),
    .wdata (rt_value),
    .ridx  (dec.rd),
    .rdata (gen_rdata)
  );

  always_comb begin
    unique case (dec.rd)
      RN_BADV:   rd_val = badv_q;
      RN_STATUS: rd_val = status_q;
      RN_CAUSE:  rd_val = cause_q;
      RN_EPC:    rd_val = epc_q;
      RN_DEBUG:  rd_val = debug_q;
      RN_DEPC:   rd_val = depc_q;
      default:   rd_val = gen_rdata;
    endcase
  end

  // Output stage: next-state then register
  logic            wb_en_d, redir_d, resv_d, cop2_d, unrec_d;
  logic            adel_d, ades_d, dref_d;
  logic [4:0]      wb_reg_d;
  logic [XLEN-1:0] wb_data_d;
  logic [RW-1:0]   redir_pc_d;
  logic            data_en;

  always_comb begin
    wb_en_d    = (dec.op == OP_MFC);
    redir_d    = (dec.op == OP_ERET) || (dec.op == OP_DERET);
    resv_d     = (dec.op == OP_RESV);
    cop2_d     = (dec.op == OP_COP2);
    unrec_d    = (dec.op == OP_UNREC);
    adel_d     = mem_fault_valid && mem_fault_unaligned && !mem_fault_write;
    ades_d     = mem_fault_valid && mem_fault_unaligned && mem_fault_write;
    dref_d     = mem_fault_valid && !mem_fault_unaligned;
    wb_reg_d   = dec.rt;
    wb_data_d  = {{EXTW{rd_val[RW-1]}}, rd_val};
    redir_pc_d = (dec.op == OP_DERET) ? depc_q : epc_q;
    data_en    = wb_en_d || redir_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_en          <= 1'b0;
      redir_valid    <= 1'b0;
      resv_instr_exc <= 1'b0;
      cop2_unhandled <= 1'b0;
      cop0_unrecog   <= 1'b0;
      addr_load_exc  <= 1'b0;
      addr_store_exc <= 1'b0;
      data_ref_exc   <= 1'b0;
    end else begin
      wb_en          <= wb_en_d;
      redir_valid    <= redir_d;
      resv_instr_exc <= resv_d;
      cop2_unhandled <= cop2_d;
      cop0_unrecog   <= unrec_d;
      addr_load_exc  <= adel_d;
      addr_store_exc <= ades_d;
      data_ref_exc   <= dref_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_reg   <= '0;
      wb_data  <= '0;
      redir_pc <= '0;
    end else if (data_en) begin
      wb_reg   <= wb_reg_d;
      wb_data  <= wb_data_d;
      redir_pc <= redir_pc_d;
    end
  end

endmodule

// File: rtl/cp0_ctrl_checker.sv
module cp0_ctrl_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        instr_valid,
  input logic [5:0]  grp,
  input logic [4:0]  sub,
  input logic [5:0]  fn,
  input logic        mem_fault_valid,
  input logic [31:0] mem_fault_addr,
  input logic        wb_en,
  input logic        redir_valid,
  input logic        resv_instr_exc,
  input logic        cop2_unhandled,
  input logic        cop0_unrecog,
  input logic [31:0] status_q,
  input logic [31:0] badv_q
);

  logic is_c0, is_ret;
  assign is_c0  = instr_valid && (grp == 6'b010000);
  assign is_ret = is_c0 && (sub == 5'h10);

  a_r2_resv: assert property (@(posedge clk) disable iff (!rst_n)
    instr_valid && (grp == 6'b010001 || grp == 6'b010011) |=> resv_instr_exc);

  a_r6_eret_exl: assert property (@(posedge clk) disable iff (!rst_n)
    is_ret && fn == 6'h18 && !status_q[2] && !mem_fault_valid
    |=> !status_q[1] && redir_valid);

  a_r6_eret_erl: assert property (@(posedge clk) disable iff (!rst_n)
    is_ret && fn == 6'h18 && status_q[2] && !mem_fault_valid
    |=> !status_q[2] && status_q[1] == $past(status_q[1]));

  a_r7_rfe_pop: assert property (@(posedge clk) disable iff (!rst_n)
    is_ret && fn == 6'h10 && !mem_fault_valid
    |=> status_q[3:0] == $past(status_q[5:2]) &&
        status_q[31:4] == $past(status_q[31:4]) && !redir_valid);

  a_r10_badv: assert property (@(posedge clk) disable iff (!rst_n)
    mem_fault_valid |=> badv_q == $past(mem_fault_addr) && status_q[1]);

  a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid && !mem_fault_valid |=> $stable(status_q) && !wb_en && !redir_valid);

  a_r9_one_result: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wb_en, redir_valid, resv_instr_exc, cop2_unhandled, cop0_unrecog}));

endmodule

bind cp0_ctrl_unit cp0_ctrl_checker u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .instr_valid     (instr_valid),
  .grp             (instr_word[31:26]),
  .sub             (instr_word[25:21]),
  .fn              (instr_word[5:0]),
  .mem_fault_valid (mem_fault_valid),
  .mem_fault_addr  (mem_fault_addr),
  .wb_en           (wb_en),
  .redir_valid     (redir_valid),
  .resv_instr_exc  (resv_instr_exc),
  .cop2_unhandled  (cop2_unhandled),
  .cop0_unrecog    (cop0_unrecog),
  .status_q        (status_q),
  .badv_q          (badv_q)
);

// File: tb/sim_cp0_ctrl_unit.sv
module sim_cp0_ctrl_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        instr_valid;
  logic [31:0] instr_word, rt_value, cur_pc;
  logic        mem_fault_valid, mem_fault_unaligned, mem_fault_write;
  logic [31:0] mem_fault_addr;
  logic        wb_en, redir_valid, resv_instr_exc, cop2_unhandled, cop0_unrecog;
  logic        addr_load_exc, addr_store_exc, data_ref_exc;
  logic [4:0]  wb_reg;
  logic [63:0] wb_data;
  logic [31:0] redir_pc;

  always #4 clk = ~clk;

  cp0_ctrl_unit u0 (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
    .rt_value(rt_value), .cur_pc(cur_pc), .mem_fault_valid(mem_fault_valid),
    .mem_fault_unaligned(mem_fault_unaligned), .mem_fault_write(mem_fault_write),
    .mem_fault_addr(mem_fault_addr), .wb_en(wb_en), .wb_reg(wb_reg), .wb_data(wb_data),
    .redir_valid(redir_valid), .redir_pc(redir_pc), .resv_instr_exc(resv_instr_exc),
    .cop2_unhandled(cop2_unhandled), .cop0_unrecog(cop0_unrecog),
    .addr_load_exc(addr_load_exc), .addr_store_exc(addr_store_exc),
    .data_ref_exc(data_ref_exc)
  );

  int total = 0;
  int bad   = 0;
  logic [31:0] model [32];

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [1:0] cop, input logic [4:0] code,
                                      input logic [4:0] rt, input logic [4:0] rd,
                                      input logic [10:0] tail);
    return {4'b0100, cop, code, rt, rd, tail};
  endfunction

  function automatic logic [63:0] sx(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  function automatic logic [7:0] flags();
    return {wb_en, redir_valid, resv_instr_exc, cop2_unhandled, cop0_unrecog,
            addr_load_exc, addr_store_exc, data_ref_exc};
  endfunction

  // drive for one edge, sample 1 ns after it
  task automatic cycle(input logic v, input logic [31:0] w, input logic [31:0] rv,
                       input logic fv, input logic fu, input logic fw,
                       input logic [31:0] fa, input logic [31:0] pc);
    @(negedge clk);
    instr_valid = v; instr_word = w; rt_value = rv; cur_pc = pc;
    mem_fault_valid = fv; mem_fault_unaligned = fu; mem_fault_write = fw;
    mem_fault_addr = fa;
    @(posedge clk);
    #1;
    instr_valid = 1'b0; mem_fault_valid = 1'b0;
  endtask

  task automatic issue(input logic [31:0] w, input logic [31:0] rv);
    cycle(1'b1, w, rv, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
  endtask

  task automatic wr_reg(input logic [4:0] rd, input logic [31:0] v);
    issue(enc(2'd0, 5'd4, 5'd9, rd, 11'd0), v);
  endtask

  task automatic rd_reg(input logic [4:0] rd, output logic [63:0] v);
    issue(enc(2'd0, 5'd0, 5'd3, rd, 11'd0), 32'h0);
    v = wb_data;
  endtask

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] v;
    rst_n = 1'b0; instr_valid = 1'b0; instr_word = '0; rt_value = '0; cur_pc = '0;
    mem_fault_valid = 1'b0; mem_fault_unaligned = 1'b0; mem_fault_write = 1'b0;
    mem_fault_addr = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 flags in reset", {56'h0, flags()}, 64'h0);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset values over every register number
    for (int r = 0; r < 32; r++) begin
      rd_reg(5'(r), v);
      chk("R1 reset value", v, (r == 12) ? 64'h4 : 64'h0);
    end

    // R3/R4: exhaustive write then read of all numbers, both variants
    for (int r = 0; r < 32; r++) begin
      logic [31:0] val;
      val = (32'(r) * 32'h9E3779B9) ^ (r[0] ? 32'h8000_0000 : 32'h0);
      model[r] = val;
      issue(enc(2'd0, r[0] ? 5'd5 : 5'd4, 5'd1, 5'(r), 11'd0), val);
      chk("R3 write no wb", {63'h0, wb_en}, 64'h0);
    end
    for (int r = 0; r < 32; r++) begin
      logic [4:0] rt;
      rt = 5'(r) ^ 5'h1F;
      issue(enc(2'd0, r[1] ? 5'd1 : 5'd0, rt, 5'(r), 11'd0), 32'h0);
      chk("R3 wb_en", {63'h0, wb_en}, 64'h1);
      chk("R3 wb_reg", {59'h0, wb_reg}, {59'h0, rt});
      chk("R4 read value", wb_data, sx(model[r]));
    end

    // R5: move with a nonzero tail
    wr_reg(5'd20, 32'h1111_2222);
    issue(enc(2'd0, 5'd4, 5'd1, 5'd20, 11'h040), 32'h7777_7777);
    chk("R5 unrecog flag", {56'h0, flags()}, 64'h08);
    rd_reg(5'd20, v);
    chk("R5 no write", v, 64'h1111_2222);

    // R6: exception return, ERL then EXL
    wr_reg(5'd12, 32'h0000_0006);
    wr_reg(5'd14, 32'h8000_1234);
    issue(enc(2'd0, 5'h10, 5'd0, 5'd0, 11'h018), 32'h0);
    chk("R6 redirect", {63'h0, redir_valid}, 64'h1);
    chk("R6 target", {32'h0, redir_pc}, 64'h8000_1234);
    rd_reg(5'd12, v);
    chk("R6 ERL cleared first", v, 64'h2);
    issue(enc(2'd0, 5'h10, 5'd0, 5'd0, 11'h7D8), 32'h0);
    chk("R6 second redirect", {32'h0, redir_pc}, 64'h8000_1234);
    rd_reg(5'd12, v);
    chk("R6 EXL cleared", v, 64'h0);

    // R7: legacy status pop over all low-6-bit patterns
    for (int p = 0; p < 64; p++) begin
      logic [31:0] old;
      old = 32'hA500_0000 | 32'(p) | (32'(p) << 10);
      wr_reg(5'd12, old);
      issue(enc(2'd0, 5'h10, 5'd0, 5'd0, 11'h010), 32'h0);
      chk("R7 no redirect", {63'h0, redir_valid}, 64'h0);
      rd_reg(5'd12, v);
      chk("R7 pop", v, sx((old & 32'hFFFF_FFF0) | ((old >> 2) & 32'hF)));
    end

    // R8: debug return
    wr_reg(5'd16, 32'hFFFF_FFFF);
    wr_reg(5'd17, 32'h9000_0040);
    issue(enc(2'd0, 5'h10, 5'd0, 5'd0, 11'h01F), 32'h0);
    chk("R8 redirect", {31'h0, redir_valid, redir_pc}, {31'h0, 1'b1, 32'h9000_0040});
    rd_reg(5'd16, v);
    chk("R8 DM cleared", v, sx(32'hBFFF_FFFF));

    // R9: other coprocessor-0 encodings
    wr_reg(5'd12, 32'h0000_0013);
    issue(enc(2'd0, 5'h10, 5'd0, 5'd0, 11'h001), 32'h0);
    chk("R9 unrecog 0x10/01", {56'h0, flags()}, 64'h08);
    issue(enc(2'd0, 5'h08, 5'd0, 5'd12, 11'h000), 32'h0);
    chk("R9 unrecog 0x08", {56'h0, flags()}, 64'h08);
    rd_reg(5'd12, v);
    chk("R9 status kept", v, 64'h13);

    // R2: coprocessor number decode
    issue(enc(2'd1, 5'd4, 5'd0, 5'd12, 11'd0), 32'hFFFF_FFFF);
    chk("R2 cop1 reserved", {56'h0, flags()}, 64'h20);
    issue(enc(2'd3, 5'd4, 5'd0, 5'd12, 11'd0), 32'hFFFF_FFFF);
    chk("R2 cop3 reserved", {56'h0, flags()}, 64'h20);
    issue(enc(2'd2, 5'd4, 5'd0, 5'd12, 11'd0), 32'hFFFF_FFFF);
    chk("R2 cop2 unhandled", {56'h0, flags()}, 64'h10);
    issue({4'b0000, 2'd0, 5'd4, 5'd0, 5'd12, 11'd0}, 32'hFFFF_FFFF);
    chk("R2 other group ignored", {56'h0, flags()}, 64'h0);
    rd_reg(5'd12, v);
    chk("R2 status kept", v, 64'h13);

    // R11: valid low
    cycle(1'b0, enc(2'd0, 5'd4, 5'd0, 5'd12, 11'd0), 32'hFFFF_FFFF,
          1'b0, 1'b0, 1'b0, 32'h0, 32'h0);
    chk("R11 no strobe", {56'h0, flags()}, 64'h0);
    rd_reg(5'd12, v);
    chk("R11 status kept", v, 64'h13);

    // R10: four fault kinds
    for (int k = 0; k < 4; k++) begin
      logic fu, fw;
      logic [31:0] fa, pc;
      logic [4:0]  code;
      fu = k[1]; fw = k[0];
      fa = 32'h1000_0003 + 32'(k); pc = 32'h0000_0400 + 32'(4 * k);
      code = fu ? (fw ? 5'd5 : 5'd4) : (fw ? 5'd3 : 5'd2);
      wr_reg(5'd12, 32'h0);
      wr_reg(5'd13, 32'h0);
      cycle(1'b0, 32'h0, 32'h0, 1'b1, fu, fw, fa, pc);
      chk("R10 flags", {56'h0, flags()}, {61'h0, fu & ~fw, fu & fw, ~fu});
      rd_reg(5'd8, v);  chk("R10 badvaddr", v, sx(fa));
      rd_reg(5'd14, v); chk("R10 epc", v, sx(pc));
      rd_reg(5'd12, v); chk("R10 exl", v, 64'h2);
      rd_reg(5'd13, v); chk("R10 cause", v, {57'h0, code, 2'b00});
    end
    cycle(1'b1, enc(2'd0, 5'd4, 5'd0, 5'd14, 11'd0), 32'h0000_0111,
          1'b1, 1'b1, 1'b0, 32'h2000_0001, 32'h0000_0222);
    rd_reg(5'd14, v);
    chk("R10 fault wins", v, 64'h222);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule